// File: doc/BRIEF.md
# Bus-Attached Asynchronous Serial Port with Error-Tagged Receive Queue

This block is an asynchronous serial transmitter and receiver. Software drives it through 8-bit register accesses on an APB slave port. Bytes written to the data register are queued in a 16-entry transmit FIFO. They are then shifted out on `txd` as framed characters. Characters arriving on `rxd` are checked for parity, framing and break conditions. Each one is queued together with its three error flags in a 16-entry receive FIFO. Bit timing comes from the bus clock: a programmable 16-bit divisor produces a tick at 16 times the baud rate. The frame has 5 to 8 data bits, optional even or odd parity, and one or two stop bits.

A single level interrupt merges four causes, each with its own enable:
- the receive FIFO reaching a fixed fill of 8 entries;
- a receive timeout;
- the transmit FIFO being empty;
- a change on one of the three active-low modem status inputs.

Receive errors never raise the interrupt. They are visible only in the receive status register, for the character currently at the head of the FIFO.

Inside the block the FIFOs, the shift engines and the register file exchange data with valid/ready handshakes. At the block edge the APB port never stalls: `pready` is held high, and every access completes in its access phase. The bus gives no back-pressure. A write to a full transmit FIFO is discarded. A character that arrives at a full receive FIFO is dropped, and a sticky overrun flag is set.

Top module: `uart_apb_errfifo`

## Requirements
- R1: After reset:
  - `txd` and `irq` are 1 and 0.
  - The format register reads 0x03.
  - The divisor reads 0x0001.
  - The interrupt enable register reads 0.
  - Receive status reads 0x00.
  - Line status reads 0x06.
  - Interrupt status reads 0x04.
- R2: A transmitted character has these parts, in order:
  - a low start bit;
  - the data bits, least significant first, with the count set by format bits [1:0] (00=5 … 11=8 bits);
  - optional parity;
  - a high stop bit.

  Every bit lasts 16×divisor clocks. The divisor is low byte at 0x3 and high byte at 0x4. Data goes in at register 0x0. The line rests high when idle.
- R3: Format bits [4:3] select parity: 01 even, 10 odd, 00 or 11 none. The parity bit follows the last data bit. For even parity, data and parity together hold an even number of ones; for odd parity, an odd number.
- R4: Format bit 2 set gives two stop bits. The line stays high for two full bit periods before the next start bit.
- R5: A character received on `rxd` is sampled at bit centres and queued. Reading register 0x0 returns the characters in arrival order, zero-extended above the data width, and removes the head.
- R6: Receive status (0x1) layout:
  - bit0: receive FIFO not empty;
  - bit1: framing error (first stop bit low);
  - bit2: parity error;
  - bit3: break (data, parity and stop all low);
  - bit4: sticky overrun.

  Bits 1 to 3 belong to the head character and change only when it is removed. Reading 0x1 removes no character.
- R7: Parity, framing and break errors never assert `irq` by themselves.
- R8: With enable bit0 (register 0x5) set, `irq` is high once 8 or more characters are queued. Interrupt status (0x6) bit0 shows this.
- R9: With enable bit0 set, `irq` rises when both of these hold:
  - 1 to 7 characters are queued;
  - no character has arrived and none has been read for 4 frame times.

  Interrupt status bit1 shows this. Reading a character clears it.
- R10: A character arriving while 16 are queued is dropped, and the overrun bit is set. Reading register 0x1 clears the overrun bit. The 16 queued characters are kept.
- R11: With enable bit1 set, `irq` is high whenever the transmit FIFO is empty. Interrupt status bit2 shows this.
- R12: Modem status (0x7) layout:
  - bits [2:0]: present active levels of DCD, CTS and DSR (inverted pins);
  - bits [5:3]: change flags in the same order.

  Any change sets its flag. Reading 0x7 clears the flags. With enable bit2 set, any flag drives `irq` (interrupt status bit3).
- R13: `pready` is high in every cycle. Reads and writes act only in the access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the baud source |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 4 | Register offset |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid in the access phase |
| pready | output | 1 | Always high, no wait states |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| dcd_n | input | 1 | Carrier detect, active low |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| irq | output | 1 | Combined interrupt |

## Verification
The transmitter's output is decoded by a behavioural line monitor and looped back into the receiver. Four frame formats are used: 8N1, 7E1 at a divisor of 3, 5O2, and 6 bits with code 11 (no parity) and two stop bits. These separate errors in data width, bit order, parity polarity and stop-bit count.

Hand-built frames carrying a bad parity bit, a low stop bit, or an all-zero break are sent on `rxd` directly. Each must produce exactly its own flag combination at the head of the queue, with no interrupt.

Three bursts tell the fill, timeout and overrun rules apart:
- eight back-to-back characters for the fill level;
- a lone character followed by silence for the timeout;
- seventeen characters for the overrun.

Toggling single modem pins exercises the change flags and their clear-on-read.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam int OVS = 16;

  typedef struct packed {
    logic [1:0] par;
    logic       stop2;
    logic [1:0] dlen;
  } frame_cfg_t;

  typedef struct packed {
    logic       brk;
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic par_enabled(input logic [1:0] par);
    return (par == 2'b01) || (par == 2'b10);
  endfunction

  function automatic logic frame_parity(input logic [7:0] d, input logic [1:0] dlen,
                                        input logic odd);
    logic [7:0] m;
    m = 8'hFF >> (2'd3 - dlen);
    return (^(d & m)) ^ odd;
  endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [W-1:0]               out_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push, pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       txd,
  output logic       busy
);
  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;

  tx_state_t  state;
  logic [3:0] sc;
  logic [2:0] bi;
  logic [7:0] sh;
  logic       pbit;
  logic       stop_left;
  logic       bit_end;

  assign in_ready = (state == TX_IDLE) && tick;
  assign busy     = (state != TX_IDLE);
  assign bit_end  = tick && (sc == 4'(OVS - 1));

  always_comb begin
    case (state)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh[0];
      TX_PAR:   txd = pbit;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      sc        <= '0;
      bi        <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      stop_left <= 1'b0;
    end else if (state == TX_IDLE) begin
      if (in_valid && in_ready) begin
        sh    <= in_data;
        pbit  <= frame_parity(in_data, cfg.dlen, cfg.par == 2'b10);
        sc    <= '0;
        state <= TX_START;
      end
    end else if (tick) begin
      sc <= sc + 1'b1;
      if (bit_end) begin
        case (state)
          TX_START: begin
            state <= TX_DATA;
            bi    <= '0;
          end
          TX_DATA: begin
            sh <= sh >> 1;
            bi <= bi + 1'b1;
            if (bi == {1'b1, cfg.dlen}) begin
              state     <= par_enabled(cfg.par) ? TX_PAR : TX_STOP;
              stop_left <= cfg.stop2;
            end
          end
          TX_PAR: begin
            state     <= TX_STOP;
            stop_left <= cfg.stop2;
          end
          default: begin
            if (stop_left) stop_left <= 1'b0;
            else           state     <= TX_IDLE;
          end
        endcase
      end
    end
  end

  // R2
  bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> $past(tick));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  frame_cfg_t cfg,
  input  logic       rxd,
  output logic       out_valid,
  output rx_entry_t  out_entry
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rx_state_t;

  rx_state_t  state;
  logic [1:0] sync;
  logic       rs;
  logic [3:0] sc;
  logic [2:0] bi;
  logic [7:0] d;
  logic       pr;
  logic       pen;
  logic       bit_mid;

  assign rs      = sync[1];
  assign pen     = par_enabled(cfg.par);
  assign bit_mid = tick && (sc == 4'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= 2'b11;
      state     <= RX_IDLE;
      sc        <= '0;
      bi        <= '0;
      d         <= '0;
      pr        <= 1'b0;
      out_valid <= 1'b0;
      out_entry <= '0;
    end else begin
      sync      <= {sync[0], rxd};
      out_valid <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (!rs) begin
            state <= RX_START;
            sc    <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (sc == 4'(OVS / 2 - 1)) begin
              sc    <= '0;
              bi    <= '0;
              d     <= '0;
              state <= rs ? RX_IDLE : RX_DATA;
            end else begin
              sc <= sc + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) sc <= sc + 1'b1;
          if (bit_mid) begin
            d[bi] <= rs;
            bi    <= bi + 1'b1;
            if (bi == {1'b1, cfg.dlen}) state <= pen ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          if (tick) sc <= sc + 1'b1;
          if (bit_mid) begin
            pr    <= rs;
            state <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (tick) sc <= sc + 1'b1;
          if (bit_mid) begin
            out_valid      <= 1'b1;
            out_entry.data <= d;
            out_entry.ferr <= !rs;
            out_entry.perr <= pen && (pr != frame_parity(d, cfg.dlen, cfg.par == 2'b10));
            out_entry.brk  <= !rs && (d == 8'h00) && (!pen || !pr);
            state          <= rs ? RX_IDLE : RX_WAITHI;
          end
        end
        default: begin
          if (rs) state <= RX_IDLE;
        end
      endcase
    end
  end

  // R6
  push_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(state) == RX_STOP));
endmodule

// File: rtl/uart_apb_errfifo.sv
module uart_apb_errfifo
  import uart_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int TX_DEPTH  = 16,
  parameter int RX_DEPTH  = 16,
  parameter int RX_TRIG   = 8,
  parameter int TMO_CHARS = 4
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [7:0]        pwdata,
  output logic [7:0]        prdata,
  output logic              pready,
  output logic              txd,
  input  logic              rxd,
  input  logic              dcd_n,
  input  logic              cts_n,
  input  logic              dsr_n,
  output logic              irq
);
  localparam int DIV_W = 16;
  localparam int TXC_W = $clog2(TX_DEPTH + 1);
  localparam int RXC_W = $clog2(RX_DEPTH + 1);
  localparam int RXE_W = $bits(rx_entry_t);
  localparam int TMO_W = $clog2(TMO_CHARS * OVS * 12 + 1);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RXST = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FMT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DIVL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DIVH = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_MST  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_LST  = ADDR_W'(8);

  frame_cfg_t        fmt;
  logic [DIV_W-1:0]  div;
  logic [2:0]        ien;
  logic              ovr;
  logic [2:0]        msync1, msync2, mprev, mdelta;
  logic [TMO_W-1:0]  tmo_cnt, tmo_lim;
  logic [3:0]        frame_bits;

  logic              acc, wr, rd;
  logic              tick;
  logic              txf_in_ready, txf_out_valid, txf_out_ready, tx_busy;
  logic [7:0]        txf_out_data;
  logic [TXC_W-1:0]  tx_cnt;
  logic              rx_valid, rxf_in_ready, rxf_out_valid, rxf_pop;
  rx_entry_t         rx_new, rx_head;
  logic [RXE_W-1:0]  rx_head_raw;
  logic [RXC_W-1:0]  rx_cnt;
  logic              c_lvl, c_tmo, c_txe, c_mod;

  assign pready  = 1'b1;
  assign acc     = psel && penable;
  assign wr      = acc && pwrite;
  assign rd      = acc && !pwrite;
  assign rxf_pop = rd && (paddr == A_DATA);
  assign rx_head = rx_entry_t'(rx_head_raw);

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(pclk), .rst_n(presetn), .div(div), .tick(tick)
  );

  uart_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txf (
    .clk(pclk), .rst_n(presetn),
    .in_valid(wr && (paddr == A_DATA)), .in_ready(txf_in_ready), .in_data(pwdata),
    .out_valid(txf_out_valid), .out_ready(txf_out_ready), .out_data(txf_out_data),
    .count(tx_cnt)
  );

  uart_tx u_tx (
    .clk(pclk), .rst_n(presetn), .tick(tick), .cfg(fmt),
    .in_valid(txf_out_valid), .in_ready(txf_out_ready), .in_data(txf_out_data),
    .txd(txd), .busy(tx_busy)
  );

  uart_rx u_rx (
    .clk(pclk), .rst_n(presetn), .tick(tick), .cfg(fmt), .rxd(rxd),
    .out_valid(rx_valid), .out_entry(rx_new)
  );

  uart_fifo #(.W(RXE_W), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(pclk), .rst_n(presetn),
    .in_valid(rx_valid), .in_ready(rxf_in_ready), .in_data(rx_new),
    .out_valid(rxf_out_valid), .out_ready(rxf_pop), .out_data(rx_head_raw),
    .count(rx_cnt)
  );

  // register writes, sticky flags and modem tracking
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      fmt    <= '{par: 2'b00, stop2: 1'b0, dlen: 2'b11};
      div    <= DIV_W'(1);
      ien    <= '0;
      ovr    <= 1'b0;
      msync1 <= '0;
      msync2 <= '0;
      mprev  <= '0;
      mdelta <= '0;
    end else begin
      if (wr) begin
        case (paddr)
          A_FMT:   fmt       <= frame_cfg_t'(pwdata[4:0]);
          A_DIVL:  div[7:0]  <= pwdata;
          A_DIVH:  div[15:8] <= pwdata;
          A_IEN:   ien       <= pwdata[2:0];
          default: ;
        endcase
      end
      if (rx_valid && !rxf_in_ready) ovr <= 1'b1;
      else if (rd && (paddr == A_RXST)) ovr <= 1'b0;
      msync1 <= ~{dsr_n, cts_n, dcd_n};
      msync2 <= msync1;
      mprev  <= msync2;
      mdelta <= ((rd && (paddr == A_MST)) ? 3'b000 : mdelta) | (msync2 ^ mprev);
    end
  end

  // receive timeout: counts oversampling ticks of line silence
  assign frame_bits = 4'd7 + {2'b00, fmt.dlen} + {3'b000, par_enabled(fmt.par)}
                    + {3'b000, fmt.stop2};
  assign tmo_lim    = TMO_W'(TMO_CHARS * OVS) * TMO_W'(frame_bits);

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) tmo_cnt <= '0;
    else if (rx_valid || rxf_pop || !rxf_out_valid) tmo_cnt <= '0;
    else if (tick && (tmo_cnt < tmo_lim)) tmo_cnt <= tmo_cnt + 1'b1;
  end

  assign c_lvl = (rx_cnt >= RXC_W'(RX_TRIG));
  assign c_tmo = rxf_out_valid && !c_lvl && (tmo_cnt >= tmo_lim);
  assign c_txe = (tx_cnt == '0);
  assign c_mod = |mdelta;
  assign irq   = (ien[0] && (c_lvl || c_tmo)) || (ien[1] && c_txe) || (ien[2] && c_mod);

  always_comb begin
    case (paddr)
      A_DATA:  prdata = rxf_out_valid ? rx_head.data : 8'h00;
      A_RXST:  prdata = {3'b000, ovr,
                         rxf_out_valid && rx_head.brk,
                         rxf_out_valid && rx_head.perr,
                         rxf_out_valid && rx_head.ferr,
                         rxf_out_valid};
      A_FMT:   prdata = {3'b000, fmt};
      A_DIVL:  prdata = div[7:0];
      A_DIVH:  prdata = div[15:8];
      A_IEN:   prdata = {5'b00000, ien};
      A_IST:   prdata = {4'b0000, c_mod, c_txe, c_tmo, c_lvl};
      A_MST:   prdata = {2'b00, mdelta, msync2};
      A_LST:   prdata = {5'b00000, c_txe && !tx_busy, c_txe, !txf_in_ready};
      default: prdata = 8'h00;
    endcase
  end

  // R10
  ovr_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(ovr) |-> ($past(rx_cnt) == RXC_W'(RX_DEPTH)));

  // R12
  mdelta_clear_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (rd && (paddr == A_MST) && (msync2 == mprev)) |=> (mdelta == 3'b000));
endmodule

// File: tb/tb_uart_apb_errfifo.sv
module tb_uart_apb_errfifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       psel, penable, pwrite;
  logic [3:0] paddr;
  logic [7:0] pwdata, prdata;
  logic       pready, txd, rxd, irq;
  logic       dcd_n, cts_n, dsr_n;
  logic       loop_en, rx_drv;

  int n_chk = 0, n_err = 0;
  int dbits = 8, bp = 16, frames_seen = 0;
  bit par_on = 0, par_odd = 0, two_stop = 0, mon_busy = 0, model_ovr = 0;
  logic [7:0]  exp_tx[$];
  logic [10:0] exp_rx[$];
  logic [7:0]  mon_d, rv;
  logic [10:0] ent;

  always #4 clk = ~clk;
  assign rxd = loop_en ? txd : rx_drv;

  uart_apb_errfifo dut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .txd(txd), .rxd(rxd), .dcd_n(dcd_n), .cts_n(cts_n), .dsr_n(dsr_n), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = v;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #2 v = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic read_check(input string req, input logic [3:0] a, input int exp);
    logic [7:0] v;
    apb_read(a, v);
    check(req, v, exp);
  endtask

  task automatic set_fmt(input logic [7:0] v);
    apb_write(4'h2, v);
    dbits    = 5 + v[1:0];
    two_stop = v[2];
    par_on   = (v[4:3] == 2'b01) || (v[4:3] == 2'b10);
    par_odd  = (v[4:3] == 2'b10);
  endtask

  task automatic set_div(input int d);
    apb_write(4'h3, d[7:0]);
    apb_write(4'h4, d[15:8]);
    bp = 16 * d;
  endtask

  task automatic send_tx(input logic [7:0] b);
    exp_tx.push_back(b & ((8'h01 << dbits) - 8'h01));
    apb_write(4'h0, b);
  endtask

  task automatic wait_frames(input int n);
    while (frames_seen < n) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  // pops n entries and compares status and data with the model queue
  task automatic drain(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      ent = exp_rx.pop_front();
      read_check({req, " status"}, 4'h1, {3'b000, model_ovr, ent[10:8], 1'b1});
      model_ovr = 0;
      read_check({req, " data"}, 4'h0, ent[7:0]);
    end
  endtask

  task automatic send_raw(input logic [10:0] bits);
    for (int i = 0; i < 11; i++) begin
      rx_drv = bits[i];
      repeat (bp) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (bp) @(negedge clk);
  endtask

  // behavioural line monitor and loopback receive model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !txd) begin
        mon_busy = 1;
        repeat (bp / 2) @(negedge clk);
        check("R2 start bit", txd, 0);
        mon_d = 8'h00;
        for (int i = 0; i < dbits; i++) begin
          repeat (bp) @(negedge clk);
          mon_d[i] = txd;
        end
        if (par_on) begin
          repeat (bp) @(negedge clk);
          check("R3 parity bit", txd, (^mon_d) ^ par_odd);
        end
        repeat (bp) @(negedge clk);
        check("R2 stop bit", txd, 1);
        if (two_stop) begin
          repeat (bp) @(negedge clk);
          check("R4 second stop bit", txd, 1);
        end
        if (exp_tx.size() == 0) check("R2 unexpected frame", 1, 0);
        else check("R2 frame data", mon_d, exp_tx.pop_front());
        if (loop_en) begin
          if (exp_rx.size() < 16) exp_rx.push_back({3'b000, mon_d});
          else model_ovr = 1;
        end
        frames_seen++;
        mon_busy = 0;
      end
    end
  end

  // per-clock comparison of the always-known outputs
  always @(negedge clk) begin
    if (rst_n) begin
      check("R13 pready", pready, 1);
      if (!mon_busy && exp_tx.size() == 0) check("R2 idle line", txd, 1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    dcd_n = 1; cts_n = 1; dsr_n = 1; loop_en = 1; rx_drv = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 txd", txd, 1);
    check("R1 irq", irq, 0);
    read_check("R1 fmt", 4'h2, 8'h03);
    read_check("R1 div lo", 4'h3, 8'h01);
    read_check("R1 div hi", 4'h4, 8'h00);
    read_check("R1 ien", 4'h5, 8'h00);
    read_check("R1 rx status", 4'h1, 8'h00);
    read_check("R1 line status", 4'h8, 8'h06);
    read_check("R1 irq status", 4'h6, 8'h04);

    // R2 R5: 8N1
    base = frames_seen;
    send_tx(8'hA5); send_tx(8'h3C); send_tx(8'hFF); send_tx(8'h00);
    wait_frames(base + 4);
    drain("R5 8N1", 4);

    // R3: 7 bits even parity, divisor 3
    set_div(3); set_fmt(8'h0A);
    base = frames_seen;
    send_tx(8'h55); send_tx(8'hFF);
    wait_frames(base + 2);
    drain("R3 7E1", 2);

    // R3 R4: 5 bits odd parity two stops, back to back
    set_div(1); set_fmt(8'h14);
    base = frames_seen;
    send_tx(8'h1F); send_tx(8'h0A); send_tx(8'h13);
    wait_frames(base + 3);
    drain("R4 5O2", 3);

    // R3 R4: 6 bits, parity code 11 means none, two stops
    set_fmt(8'h1D);
    base = frames_seen;
    send_tx(8'h2A); send_tx(8'h15);
    wait_frames(base + 2);
    drain("R3 6N2", 2);

    // R11: transmit-empty interrupt
    set_fmt(8'h03); set_div(4);
    apb_write(4'h5, 8'h02);
    repeat (3) @(negedge clk);
    check("R11 irq while tx empty", irq, 1);
    base = frames_seen;
    send_tx(8'h81); send_tx(8'h7E);
    repeat (10) @(negedge clk);
    check("R11 irq with queued byte", irq, 0);
    wait_frames(base + 2);
    check("R11 irq after drain", irq, 1);
    drain("R11 loop", 2);
    apb_write(4'h5, 8'h00);
    set_div(1);

    // R12: modem change flags
    apb_write(4'h5, 8'h04);
    cts_n = 0;
    repeat (6) @(negedge clk);
    check("R12 irq on cts change", irq, 1);
    read_check("R12 mstat cts", 4'h7, 8'h12);
    repeat (2) @(negedge clk);
    check("R12 irq cleared by read", irq, 0);
    read_check("R12 mstat after clear", 4'h7, 8'h02);
    cts_n = 1; dsr_n = 0;
    repeat (6) @(negedge clk);
    read_check("R12 mstat dsr", 4'h7, 8'h34);
    dsr_n = 1;
    repeat (6) @(negedge clk);
    read_check("R12 mstat dsr release", 4'h7, 8'h20);
    apb_write(4'h5, 8'h00);

    // R8: fill level of 8
    apb_write(4'h5, 8'h01);
    base = frames_seen;
    for (int i = 0; i < 8; i++) send_tx(8'h10 + i);
    wait_frames(base + 7);
    check("R8 irq at 7 entries", irq, 0);
    wait_frames(base + 8);
    check("R8 irq at 8 entries", irq, 1);
    read_check("R8 irq status", 4'h6, 8'h05);
    drain("R8 burst", 8);
    check("R8 irq after drain", irq, 0);

    // R9: receive timeout
    base = frames_seen;
    send_tx(8'h6D);
    wait_frames(base + 1);
    check("R9 irq before timeout", irq, 0);
    repeat (700) @(negedge clk);
    check("R9 irq after timeout", irq, 1);
    read_check("R9 irq status", 4'h6, 8'h06);
    drain("R9 single", 1);
    repeat (2) @(negedge clk);
    check("R9 irq cleared by read", irq, 0);

    // R6 R7: error-tagged frames driven on rxd, 8 bits even parity
    loop_en = 0;
    set_fmt(8'h0B);
    send_raw({1'b1, 1'b1, 8'h5A, 1'b0});
    exp_rx.push_back({3'b010, 8'h5A});
    repeat (20) @(negedge clk);
    check("R7 no irq on parity error", irq, 0);
    send_raw({1'b0, 1'b0, 8'h33, 1'b0});
    exp_rx.push_back({3'b001, 8'h33});
    repeat (20) @(negedge clk);
    check("R7 no irq on framing error", irq, 0);
    send_raw(11'h000);
    exp_rx.push_back({3'b101, 8'h00});
    repeat (20) @(negedge clk);
    check("R7 no irq on break", irq, 0);
    send_raw({1'b1, 1'b0, 8'hC3, 1'b0});
    exp_rx.push_back({3'b000, 8'hC3});
    repeat (20) @(negedge clk);
    read_check("R6 status read keeps head", 4'h1, 8'h05);
    drain("R6 tagged", 4);
    read_check("R6 empty status", 4'h1, 8'h00);
    apb_write(4'h5, 8'h00);
    loop_en = 1;

    // R10: overrun with 17 characters
    set_fmt(8'h03);
    base = frames_seen;
    for (int i = 0; i < 16; i++) send_tx(8'h40 + i);
    wait_frames(base + 1);
    send_tx(8'h50);
    wait_frames(base + 17);
    check("R10 model flagged overrun", model_ovr, 1);
    drain("R10 overrun", 16);
    read_check("R10 overrun cleared", 4'h1, 8'h00);

    summary();
    $finish;
  end
endmodule